// File: doc/BRIEF.md
# Serial EEPROM Chunked Access Sequencer

This block turns one host request into the whole sequence of serial EEPROM transactions it needs. The host gives a direction, a 16-bit start address and a byte count. The block splits the request into chunks of at most `CHUNK_MAX` bytes. For each chunk it sends a framed command: opcode, address high byte, address low byte, then the payload. Write chunks get a write-enable frame in front and status polling behind.

The block does not drive the serial wires itself. It drives a byte-exchange engine through a simple request/acknowledge pair. The block holds `xfer_req` and `xfer_tx` until the engine returns `xfer_ack`, and the received byte `xfer_rx` is valid in that same cycle. The block frames transactions with `spi_sel`.

Payload moves over two valid/ready streams:
- **Write stream:** a byte moves on `wr_valid && wr_ready`. The host must hold `wr_valid` and `wr_data` steady until that cycle.
- **Read stream:** the block holds `rd_valid` and `rd_data` steady until `rd_ready`. It exchanges no further byte while a read byte waits, so the host may apply back-pressure at any time.

Top module: `spi_eeprom_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `timeout`, `spi_sel`, `xfer_req`, `wr_ready` and `rd_valid` are all 0. A `start` is taken only while `busy` is 0, and `busy` stays 1 until the operation ends.
- R2: The opcode bytes are 0x06 (write enable), 0x02 (write array), 0x03 (read array) and 0x05 (read status).
- R3: A command frame carries, in this order, the opcode, the address bits [15:8], the address bits [7:0], and then the data. `spi_sel` is 1 for the whole frame and drops for at least one cycle between any two frames. `xfer_req` is only ever 1 while `spi_sel` is 1.
- R4: No frame carries more than `CHUNK_MAX` (16) data bytes. Chunk k starts at address start+16·k, modulo 65536. The last chunk carries the remainder.
- R5: Every write chunk is preceded by its own one-byte write-enable frame.
- R6: After each write chunk, the block sends a two-byte status frame (0x05, then a dummy 0x00). Bit 0 of the second received byte is the device busy bit. The block repeats the status frame until that bit is 0, up to `POLL_LIMIT` frames. If the limit is reached, `timeout` is set and the remaining chunks are still carried out. `timeout` is cleared by the next accepted `start`.
- R7: Between two consecutive status frames, `spi_sel` stays 0 for at least `POLL_GAP` cycles.
- R8: In a read frame, the three bytes received during the header are dropped. The payload bytes appear on the read stream in address order. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds and no byte is exchanged.
- R9: A write payload byte is consumed in the cycle `wr_ready` is 1. `wr_ready` is 1 only in the cycle the engine acknowledges that byte. While `wr_valid` is 0, the frame waits.
- R10: `done` pulses for exactly one cycle, in the cycle `busy` falls, and only after the last read byte has been taken. A zero-length request completes with no frame.
- R11: `xfer_req` and `xfer_tx` stay stable from the cycle a byte is requested until the cycle of its `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| write_mode | input | 1 | 1 = write request, 0 = read request |
| start_addr | input | 16 | First EEPROM byte address |
| length | input | LEN_W | Number of payload bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | Status polling hit its limit during this operation |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Write payload byte consumed |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte present |
| rd_ready | input | 1 | Host takes the read byte |
| spi_sel | output | 1 | Chip select, active high, spans a frame |
| xfer_req | output | 1 | Byte exchange request |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Engine finished the exchange |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |

## Verification
The bench builds the block with `POLL_LIMIT` = 5 and `POLL_GAP` = 4, and keeps `CHUNK_MAX` = 16 and `LEN_W` = 16. These small poll values let a device that never goes ready exhaust the attempt limit within a few dozen cycles, so the timeout path and its continuation into the next chunk are exercised. They also make the poll spacing cheap to measure. With the full chunk size, requests of 37 and 20 bytes give three-chunk and two-chunk operations, and a start near 0xFFF8 forces the chunk address to wrap.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  localparam logic [7:0] OP_WR_EN  = 8'h06;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] DUMMY     = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_WREN, S_REL1, S_OPC, S_AHI, S_ALO, S_DATA,
    S_REL2, S_SOP, S_SDUM, S_PREL, S_PWAIT, S_FIN
  } seq_state_e;
endpackage

// File: rtl/eeprom_chunk_split.sv
module eeprom_chunk_split #(
  parameter int CHUNK_MAX = 16,
  parameter int LEN_W     = 16,
  localparam int CW       = $clog2(CHUNK_MAX + 1)
) (
  input  logic [LEN_W-1:0] remaining,
  output logic [CW-1:0]    chunk_len,
  output logic [LEN_W-1:0] rem_after
);
  always_comb begin
    if (remaining > LEN_W'(CHUNK_MAX)) chunk_len = CW'(CHUNK_MAX);
    else                               chunk_len = CW'(remaining);
    rem_after = remaining - LEN_W'(chunk_len);
  end
endmodule

// File: rtl/eeprom_poll_pacer.sv
module eeprom_poll_pacer #(
  parameter int GAP_CYCLES = 50000,
  parameter int MAX_TRIES  = 1000,
  localparam int GW        = $clog2(GAP_CYCLES + 1),
  localparam int TW        = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tries_clr,
  input  logic retry,
  output logic last_try,
  output logic gap_busy
);
  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tries;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      tries   <= '0;
    end else begin
      if (retry)                gap_cnt <= GW'(GAP_CYCLES);
      else if (gap_cnt != '0)   gap_cnt <= gap_cnt - GW'(1);
      if (tries_clr)            tries <= '0;
      else if (retry)           tries <= tries + TW'(1);
    end
  end

  assign gap_busy = (gap_cnt != '0);
  assign last_try = (tries == TW'(MAX_TRIES - 1));

  // R6
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(MAX_TRIES));
  // R7
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> !gap_busy);
endmodule

// File: rtl/spi_eeprom_sequencer.sv
module spi_eeprom_sequencer
  import eeprom_seq_pkg::*;
#(
  parameter int CHUNK_MAX  = 16,
  parameter int LEN_W      = 16,
  parameter int POLL_LIMIT = 1000,
  parameter int POLL_GAP   = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             write_mode,
  input  logic [15:0]      start_addr,
  input  logic [LEN_W-1:0] length,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             spi_sel,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx
);
  localparam int CW = $clog2(CHUNK_MAX + 1);

  seq_state_e       state;
  logic             wr_q, to_q, done_q, rdv_q, st_busy_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] rem_q, rem_after;
  logic [CW-1:0]    clen_q, bcnt, chunk_len;
  logic [7:0]       rdd_q;
  logic             last_try, gap_busy, tries_clr, retry;

  eeprom_chunk_split #(.CHUNK_MAX(CHUNK_MAX), .LEN_W(LEN_W)) u_split (
    .remaining(rem_q), .chunk_len(chunk_len), .rem_after(rem_after));

  assign tries_clr = (state == S_REL2);
  assign retry     = (state == S_PREL) && st_busy_q && !last_try;

  eeprom_poll_pacer #(.GAP_CYCLES(POLL_GAP), .MAX_TRIES(POLL_LIMIT)) u_pacer (
    .clk(clk), .rst_n(rst_n), .tries_clr(tries_clr), .retry(retry),
    .last_try(last_try), .gap_busy(gap_busy));

  // Frame drive: select, request and byte to send per state
  always_comb begin
    spi_sel  = 1'b0;
    xfer_req = 1'b0;
    xfer_tx  = DUMMY;
    unique case (state)
      S_WREN: begin spi_sel = 1'b1; xfer_req = 1'b1; xfer_tx = OP_WR_EN; end
      S_OPC:  begin spi_sel = 1'b1; xfer_req = 1'b1; xfer_tx = wr_q ? OP_WRITE : OP_READ; end
      S_AHI:  begin spi_sel = 1'b1; xfer_req = 1'b1; xfer_tx = addr_q[15:8]; end
      S_ALO:  begin spi_sel = 1'b1; xfer_req = 1'b1; xfer_tx = addr_q[7:0]; end
      S_DATA: begin
        spi_sel = 1'b1;
        if (wr_q) begin xfer_req = wr_valid; xfer_tx = wr_data; end
        else            xfer_req = !rdv_q;
      end
      S_SOP:  begin spi_sel = 1'b1; xfer_req = 1'b1; xfer_tx = OP_STATUS; end
      S_SDUM: begin spi_sel = 1'b1; xfer_req = 1'b1; end
      default: ;
    endcase
  end

  assign wr_ready = (state == S_DATA) && wr_q && xfer_ack;
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign timeout  = to_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      wr_q      <= 1'b0;
      to_q      <= 1'b0;
      done_q    <= 1'b0;
      rdv_q     <= 1'b0;
      st_busy_q <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      clen_q    <= '0;
      bcnt      <= '0;
      rdd_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          wr_q   <= write_mode;
          addr_q <= start_addr;
          rem_q  <= length;
          to_q   <= 1'b0;
          state  <= (length == '0) ? S_FIN : S_PLAN;
        end
        S_PLAN: begin
          clen_q <= chunk_len;
          bcnt   <= '0;
          state  <= wr_q ? S_WREN : S_OPC;
        end
        S_WREN: if (xfer_ack) state <= S_REL1;
        S_REL1: state <= S_OPC;
        S_OPC:  if (xfer_ack) state <= S_AHI;
        S_AHI:  if (xfer_ack) state <= S_ALO;
        S_ALO:  if (xfer_ack) state <= S_DATA;
        S_DATA: if (xfer_ack) begin
          if (!wr_q) begin
            rdd_q <= xfer_rx;
            rdv_q <= 1'b1;
          end
          if (bcnt == clen_q - CW'(1)) begin
            addr_q <= addr_q + 16'(clen_q);
            rem_q  <= rem_after;
            state  <= S_REL2;
          end else begin
            bcnt <= bcnt + CW'(1);
          end
        end
        S_REL2: if (wr_q)              state <= S_SOP;
                else if (rem_q == '0)  state <= S_FIN;
                else                   state <= S_PLAN;
        S_SOP:  if (xfer_ack) state <= S_SDUM;
        S_SDUM: if (xfer_ack) begin
          st_busy_q <= xfer_rx[0];
          state     <= S_PREL;
        end
        S_PREL: begin
          if (!st_busy_q || last_try) begin
            if (st_busy_q) to_q <= 1'b1;
            state <= (rem_q == '0) ? S_FIN : S_PLAN;
          end else begin
            state <= S_PWAIT;
          end
        end
        S_PWAIT: if (!gap_busy) state <= S_SOP;
        S_FIN: if (!rdv_q || rd_ready) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> spi_sel);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_tx));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));
  // R10
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  // R4
  chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DATA |-> bcnt < CW'(CHUNK_MAX));
  // R6
  timeout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> busy);
endmodule

// File: tb/tb_spi_eeprom_sequencer.sv
`timescale 1ns/1ps
module tb_spi_eeprom_sequencer;
  localparam int TB_LIMIT = 5;
  localparam int TB_GAP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, write_mode = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] length = '0;
  logic busy, done, timeout;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1'b0;
  logic spi_sel, xfer_req, xfer_ack;
  logic [7:0] xfer_tx, xfer_rx;

  always #5 clk = ~clk;

  spi_eeprom_sequencer #(.CHUNK_MAX(16), .LEN_W(16), .POLL_LIMIT(TB_LIMIT), .POLL_GAP(TB_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
    .start_addr(start_addr), .length(length), .busy(busy), .done(done),
    .timeout(timeout), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .spi_sel(spi_sel), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx));

  // ---------------- device and byte-engine model ----------------
  logic mclr = 1'b0;
  int busy_cfg = 2;
  logic [7:0] mem [1024];
  logic ack_m; logic [7:0] rx_m;
  logic sel_d, wel;
  int idx, low_cnt, gap_hold, min_gap, busy_left;
  logic [7:0] cur_op, prev_op;
  logic [15:0] fa, da;
  int n_wren, n_wrf, n_rdf, n_st, n_nowel, max_nd, last_nd, nfa;
  logic [15:0] fr_addr [8];
  assign xfer_ack = ack_m;
  assign xfer_rx  = rx_m;

  always @(posedge clk) begin
    if (!rst_n || mclr) begin
      ack_m <= 0; rx_m <= 0; sel_d <= 0; wel <= 0; idx <= 0; low_cnt <= 0;
      gap_hold <= 0; min_gap <= 1000; busy_left <= 0; cur_op <= 0; prev_op <= 0;
      fa <= 0; n_wren <= 0; n_wrf <= 0; n_rdf <= 0; n_st <= 0; n_nowel <= 0;
      max_nd <= 0; last_nd <= 0; nfa <= 0;
    end else begin
      sel_d   <= spi_sel;
      low_cnt <= spi_sel ? 0 : low_cnt + 1;
      if (spi_sel && !sel_d) begin gap_hold <= low_cnt; prev_op <= cur_op; end
      if (sel_d && !spi_sel) begin
        idx <= 0;
        case (cur_op)
          8'h06: begin wel <= 1; n_wren <= n_wren + 1; end
          8'h02, 8'h03: begin
            if (cur_op == 8'h02) begin
              n_wrf <= n_wrf + 1; if (!wel) n_nowel <= n_nowel + 1;
              wel <= 0; busy_left <= busy_cfg;
            end else n_rdf <= n_rdf + 1;
            last_nd <= idx - 3;
            if (idx - 3 > max_nd) max_nd <= idx - 3;
            if (nfa < 8) begin fr_addr[nfa] <= fa; nfa <= nfa + 1; end
          end
          8'h05: begin
            n_st <= n_st + 1;
            if (busy_left > 0) busy_left <= busy_left - 1;
            if (prev_op == 8'h05 && gap_hold < min_gap) min_gap <= gap_hold;
          end
          default: ;
        endcase
      end
      if (xfer_req && !ack_m) begin
        ack_m <= 1; idx <= idx + 1; rx_m <= 8'hA5;
        case (idx)
          0: cur_op <= xfer_tx;
          1: begin
            fa[15:8] <= xfer_tx;
            if (cur_op == 8'h05) rx_m <= {7'd0, busy_left != 0};
          end
          2: fa[7:0] <= xfer_tx;
          default: begin
            da = fa + 16'(idx - 3);
            if (cur_op == 8'h02 && wel) mem[da[9:0]] <= xfer_tx;
            if (cur_op == 8'h03) rx_m <= mem[da[9:0]];
          end
        endcase
      end else ack_m <= 0;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  logic [7:0] shadow [1024];
  logic [7:0] src [64];
  logic [7:0] got [64];
  int got_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input logic [15:0] a, input int n, input int vid,
                        input bit stall, output bit seen_done);
    int cyc;
    @(negedge clk); mclr = 1; @(negedge clk); mclr = 0;
    got_n = 0;
    for (int k = 0; k < n; k++) begin
      src[k] = 8'(vid * 29 + k * 7 + 3);
      if (w) begin da = a + 16'(k); shadow[da[9:0]] = src[k]; end
    end
    start = 1; write_mode = w; start_addr = a; length = 16'(n);
    @(negedge clk); start = 0;
    fork
      begin : feeder
        int k = 0;
        if (w) begin
          wr_valid = (n > 0); wr_data = src[0];
          while (k < n) begin
            @(negedge clk);
            if (wr_ready) begin
              @(posedge clk); #1; k++;
              wr_valid = (k < n); wr_data = src[k % 64];
            end
          end
        end
      end
      begin : collector
        int ph = 0;
        forever begin
          @(negedge clk);
          rd_ready = stall ? ((ph % 3) != 0) : 1'b1; ph++;
          if (rd_valid && rd_ready && got_n < 64) begin got[got_n] = rd_data; got_n++; end
        end
      end
    join_none
    seen_done = 0; cyc = 0;
    while (cyc < 20000) begin
      @(negedge clk);
      if (done) begin seen_done = 1; break; end
      cyc++;
    end
    disable fork;
    wr_valid = 0; rd_ready = 0;
  endtask

  typedef struct packed { logic w; logic [15:0] a; logic [7:0] n; } vec_t;
  localparam vec_t VEC [10] = '{
    '{1'b1, 16'h0010, 8'd5},  '{1'b0, 16'h0010, 8'd5},
    '{1'b1, 16'h0100, 8'd16}, '{1'b0, 16'h0100, 8'd16},
    '{1'b1, 16'h0200, 8'd37}, '{1'b0, 16'h0200, 8'd37},
    '{1'b0, 16'h0205, 8'd3},  '{1'b1, 16'hFFF8, 8'd20},
    '{1'b0, 16'hFFF8, 8'd20}, '{1'b0, 16'h0008, 8'd4}};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !timeout, "R1 busy/done/timeout at reset", {busy, done, timeout}, 0);
    chk(!spi_sel && !xfer_req && !wr_ready && !rd_valid, "R1 bus idle at reset",
        {spi_sel, xfer_req, wr_ready, rd_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      int n = int'(VEC[v].n);
      int ch = (n + 15) / 16;
      run_op(VEC[v].w, VEC[v].a, n, v, !VEC[v].w, ok);
      chk(ok, "R10 done pulse seen", ok, 1);
      chk(!timeout, "R6 no timeout on ready device", timeout, 0);
      chk(max_nd <= 16, "R4 chunk size bound", max_nd, 16);
      chk(last_nd == n - 16 * (ch - 1), "R4 remainder in final chunk", last_nd, n - 16 * (ch - 1));
      for (int i = 0; i < ch; i++)
        chk(fr_addr[i] == 16'(int'(VEC[v].a) + 16 * i), "R3 R4 chunk address big-endian",
            fr_addr[i], 16'(int'(VEC[v].a) + 16 * i));
      if (VEC[v].w) begin
        chk(n_wrf == ch, "R2 write frames", n_wrf, ch);
        chk(n_wren == ch && n_nowel == 0, "R5 write enable per chunk", n_wren, ch);
        chk(n_st == 3 * ch, "R6 status polls", n_st, 3 * ch);
        chk(min_gap >= TB_GAP, "R7 poll spacing", min_gap, TB_GAP);
      end else begin
        chk(n_rdf == ch && n_wren == 0 && n_st == 0, "R2 read frames only", n_rdf, ch);
        chk(got_n == n, "R8 read byte count", got_n, n);
        for (int k = 0; k < n; k++) begin
          da = VEC[v].a + 16'(k);
          chk(got[k] == shadow[da[9:0]], "R8 R9 read data", got[k], shadow[da[9:0]]);
        end
      end
    end

    // R10 zero-length request
    run_op(1'b0, 16'h0030, 0, 20, 1'b0, ok);
    chk(ok && n_rdf == 0 && n_wrf == 0 && n_wren == 0, "R10 zero length", n_rdf + n_wrf, 0);

    // R6 device ready on first poll
    busy_cfg = 0;
    run_op(1'b1, 16'h0300, 20, 21, 1'b0, ok);
    chk(ok && n_st == 2, "R6 single poll per chunk", n_st, 2);

    // R6 timeout: device never ready
    busy_cfg = 100;
    run_op(1'b1, 16'h0040, 20, 22, 1'b0, ok);
    chk(ok, "R6 op completes after timeout", ok, 1);
    chk(timeout, "R6 timeout flag set", timeout, 1);
    chk(n_st == 2 * TB_LIMIT, "R6 poll limit", n_st, 2 * TB_LIMIT);
    chk(n_wrf == 2, "R6 later chunk still written", n_wrf, 2);
    chk(min_gap >= TB_GAP, "R7 poll spacing on retries", min_gap, TB_GAP);

    // R6 next start clears timeout
    busy_cfg = 2;
    run_op(1'b0, 16'h0040, 20, 23, 1'b1, ok);
    chk(ok && !timeout, "R6 timeout cleared by start", timeout, 0);
    for (int k = 0; k < 20; k++) begin
      da = 16'h0040 + 16'(k);
      chk(got[k] == shadow[da[9:0]], "R8 data after timed-out write", got[k], shadow[da[9:0]]);
    end
    chk(!busy && !spi_sel, "R1 idle after ops", {busy, spi_sel}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule